// File: doc/BRIEF.md
# Reset Cause Sequencer

The block merges four reasons for a system reset into a single reset sequence: the bidirectional reset pad being pulled low from outside, a low-supply indication, a watchdog timeout pulse and an undefined-instruction pulse from the core. Any of these starts a drive phase in which the block pulls the reset pad low through an open-drain style drive enable. The rest of the board therefore sees every reset, including those that start inside the chip. After the drive phase the block waits until the pad reads high through a two-flop synchroniser. It then keeps the core in reset for a stabilisation count chosen by the clock source, and only after that lets the core leave reset and fetch its reset vector.

The drive phase has a minimum length in clock cycles. A low-supply reset stretches it for as long as the supply stays low. An external reset stretches the sequence for as long as the pad is held low from outside. Two cause flags record why the last reset happened. The low-supply flag is sticky across later resets of any kind until it is cleared with a one-cycle strobe. A low-supply reset always leaves the watchdog flag cleared.

Top module: `reset_cause_sequencer`

## Requirements
- R1: From the running state (coreRstN high), a wdogPulse, a badOpPulse or a high lowVolt sampled at a clock edge makes padDriveLow high and coreRstN low from that edge on. A low level on padIn reaches the controller through two synchronising flops, so padDriveLow goes high at the third edge after padIn falls.
- R2: When a wdogPulse or badOpPulse starts a reset and lowVolt stays low, padDriveLow stays high for exactly MIN_PHASE cycles.
- R3: When lowVolt is high for L consecutive cycles starting from the running state, padDriveLow stays high for max(L, MIN_PHASE) cycles.
- R4: After padDriveLow falls, coreRstN stays low until the synchronised pad reads high. With no outside hold this takes 3 cycles. If the pad is held low from outside, the stabilisation count starts at the third edge after the pad is released.
- R5: The stabilisation phase lasts STAB_SHORT cycles when clkSrcRes is 0 (RC or external clock) and STAB_LONG cycles when clkSrcRes is 1 (resonator). coreRstN rises at its end.
- R6: The flags read {wdogFlag, lvdFlag}. A watchdog or undefined-instruction reset sets wdogFlag to 1. A low-supply reset sets lvdFlag to 1 and forces wdogFlag to 0. An external pad reset forces wdogFlag to 0 and leaves lvdFlag unchanged.
- R7: lvdFlag stays set through later resets of any cause. A one-cycle flagClr clears both flags. A cause arriving in the same cycle as flagClr takes priority over the clear.
- R8: A wdogPulse or badOpPulse that arrives during the stabilisation phase restarts the sequence: a full MIN_PHASE drive, the pad wait and a full stabilisation count.
- R9: While porN is low, padDriveLow is high, coreRstN is low and both flags are 0. After porN rises, a complete sequence runs before coreRstN goes high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | CPU clock |
| porN | input | 1 | Asynchronous power-on reset, active low |
| padIn | input | 1 | Level read back from the reset pad (low = reset asserted) |
| padDriveLow | output | 1 | Open-drain enable; 1 pulls the reset pad low |
| lowVolt | input | 1 | Digital low-supply indication, active high level |
| wdogPulse | input | 1 | One-cycle watchdog timeout pulse |
| badOpPulse | input | 1 | One-cycle undefined-instruction pulse |
| clkSrcRes | input | 1 | 1 = resonator clock source (long stabilisation), 0 = RC or external clock |
| flagClr | input | 1 | One-cycle strobe that clears both cause flags |
| coreRstN | output | 1 | Reset to the core, active low |
| wdogFlag | output | 1 | Watchdog / undefined-instruction cause flag |
| lvdFlag | output | 1 | Sticky low-supply cause flag |

## Verification
The assertions assume that wdogPulse, badOpPulse and flagClr are single-cycle strobes. They also assume that clkSrcRes is steady for the whole stabilisation phase, and that padIn reads low whenever padDriveLow is high, as a real open-drain pad would. The bench keeps to this by modelling the pad as the wired-AND of the block's drive and an outside hold, and by changing clkSrcRes only while the core is running. It also raises strobes for exactly one cycle, on falling edges.

// File: rtl/rstseq_pkg.sv
package rstseq_pkg;

  typedef enum logic [1:0] {
    ST_PULSE = 2'd0,
    ST_HOLD  = 2'd1,
    ST_STAB  = 2'd2,
    ST_RUN   = 2'd3
  } rstPhase_e;

  typedef struct packed {
    logic cntClr;
    logic cntEn;
    logic extStart;
  } seqStrobe_t;

endpackage

// File: rtl/rstseq_datapath.sv
module rstseq_datapath
  import rstseq_pkg::*;
#(
  parameter int CW = 13
) (
  input  logic          clk,
  input  logic          porN,
  input  logic          padIn,
  input  logic          lowVolt,
  input  logic          wdogPulse,
  input  logic          badOpPulse,
  input  logic          flagClr,
  input  seqStrobe_t    strobe,
  output logic          padSync,
  output logic [CW-1:0] cnt,
  output logic          wdogFlag,
  output logic          lvdFlag
);

  logic syncMeta;
  logic wdSet;
  logic wdDrop;

  // two-stage synchroniser on the pad readback
  always_ff @(posedge clk or negedge porN) begin
    if (!porN) begin
      syncMeta <= 1'b0;
      padSync  <= 1'b0;
    end else begin
      syncMeta <= padIn;
      padSync  <= syncMeta;
    end
  end

  // phase counter
  always_ff @(posedge clk or negedge porN) begin
    if (!porN)              cnt <= '0;
    else if (strobe.cntClr) cnt <= '0;
    else if (strobe.cntEn)  cnt <= cnt + 1'b1;
  end

  // cause flags; set sources win over the software clear
  assign wdSet  = (wdogPulse | badOpPulse) & ~lowVolt;
  assign wdDrop = lowVolt | strobe.extStart | flagClr;

  always_ff @(posedge clk or negedge porN) begin
    if (!porN) begin
      wdogFlag <= 1'b0;
      lvdFlag  <= 1'b0;
    end else begin
      if (wdSet)       wdogFlag <= 1'b1;
      else if (wdDrop) wdogFlag <= 1'b0;
      if (lowVolt)      lvdFlag <= 1'b1;
      else if (flagClr) lvdFlag <= 1'b0;
    end
  end

  a_r6_lvd_clears_wdog: assert property (@(posedge clk) disable iff (!porN)
    lowVolt |=> (lvdFlag && !wdogFlag));

  a_r6_wdog_sets_flag: assert property (@(posedge clk) disable iff (!porN)
    ((wdogPulse || badOpPulse) && !lowVolt) |=> wdogFlag);

  a_r7_lvd_sticky: assert property (@(posedge clk) disable iff (!porN)
    (lvdFlag && !flagClr) |=> lvdFlag);

  a_r7_clear_both: assert property (@(posedge clk) disable iff (!porN)
    (flagClr && !lowVolt && !wdogPulse && !badOpPulse) |=> (!lvdFlag && !wdogFlag));

endmodule

// File: rtl/rstseq_ctrl.sv
module rstseq_ctrl
  import rstseq_pkg::*;
#(
  parameter int MIN_PHASE  = 240,
  parameter int STAB_SHORT = 256,
  parameter int STAB_LONG  = 4096,
  parameter int CW         = 13
) (
  input  logic          clk,
  input  logic          porN,
  input  logic          padSync,
  input  logic          lowVolt,
  input  logic          wdogPulse,
  input  logic          badOpPulse,
  input  logic          clkSrcRes,
  input  logic [CW-1:0] cnt,
  output seqStrobe_t    strobe,
  output logic          padDriveLow,
  output logic          coreRstN
);

  localparam logic [CW-1:0] MIN_LAST   = CW'(MIN_PHASE - 1);
  localparam logic [CW-1:0] SHORT_LAST = CW'(STAB_SHORT - 1);
  localparam logic [CW-1:0] LONG_LAST  = CW'(STAB_LONG - 1);

  rstPhase_e state, stateNext;
  logic      pulseEv;
  logic      anyInt;
  logic [CW-1:0] stabLast;

  assign pulseEv  = wdogPulse | badOpPulse;
  assign anyInt   = pulseEv | lowVolt;
  assign stabLast = clkSrcRes ? LONG_LAST : SHORT_LAST;

  always_comb begin
    stateNext       = state;
    strobe.cntClr   = 1'b0;
    strobe.cntEn    = (state != ST_RUN);
    strobe.extStart = 1'b0;
    unique case (state)
      ST_RUN: begin
        if (anyInt || !padSync) begin
          stateNext       = ST_PULSE;
          strobe.cntClr   = 1'b1;
          strobe.extStart = !padSync;
        end
      end
      ST_PULSE: begin
        if (pulseEv) begin
          strobe.cntClr = 1'b1;
        end else if (cnt >= MIN_LAST && !lowVolt) begin
          stateNext     = ST_HOLD;
          strobe.cntClr = 1'b1;
        end
      end
      ST_HOLD: begin
        if (anyInt) begin
          stateNext     = ST_PULSE;
          strobe.cntClr = 1'b1;
        end else if (padSync) begin
          stateNext     = ST_STAB;
          strobe.cntClr = 1'b1;
        end
      end
      ST_STAB: begin
        if (anyInt || !padSync) begin
          stateNext       = ST_PULSE;
          strobe.cntClr   = 1'b1;
          strobe.extStart = !padSync;
        end else if (cnt >= stabLast) begin
          stateNext = ST_RUN;
        end
      end
      default: stateNext = ST_PULSE;
    endcase
  end

  always_ff @(posedge clk or negedge porN) begin
    if (!porN) state <= ST_PULSE;
    else       state <= stateNext;
  end

  assign padDriveLow = (state == ST_PULSE);
  assign coreRstN    = (state == ST_RUN);

  a_r1_internal_start: assert property (@(posedge clk) disable iff (!porN)
    (coreRstN && anyInt) |=> (padDriveLow && !coreRstN));

  a_r2_min_drive: assert property (@(posedge clk) disable iff (!porN)
    $fell(padDriveLow) |-> ($past(cnt) >= MIN_LAST));

  a_r3_lvd_extends: assert property (@(posedge clk) disable iff (!porN)
    (padDriveLow && lowVolt) |=> padDriveLow);

  a_r4_wait_pad_high: assert property (@(posedge clk) disable iff (!porN)
    (state == ST_HOLD && !padSync) |=> (state != ST_STAB));

  a_r5_stab_length: assert property (@(posedge clk) disable iff (!porN)
    $rose(coreRstN) |-> ($past(cnt) == ($past(clkSrcRes) ? LONG_LAST : SHORT_LAST)));

endmodule

// File: rtl/reset_cause_sequencer.sv
module reset_cause_sequencer
  import rstseq_pkg::*;
#(
  parameter int MIN_PHASE  = 240,
  parameter int STAB_SHORT = 256,
  parameter int STAB_LONG  = 4096
) (
  input  logic clk,
  input  logic porN,
  input  logic padIn,
  output logic padDriveLow,
  input  logic lowVolt,
  input  logic wdogPulse,
  input  logic badOpPulse,
  input  logic clkSrcRes,
  input  logic flagClr,
  output logic coreRstN,
  output logic wdogFlag,
  output logic lvdFlag
);

  localparam int CNT_TOP = (MIN_PHASE > STAB_SHORT) ?
                           ((MIN_PHASE > STAB_LONG) ? MIN_PHASE : STAB_LONG) :
                           ((STAB_SHORT > STAB_LONG) ? STAB_SHORT : STAB_LONG);
  localparam int CW = $clog2(CNT_TOP + 1);

  seqStrobe_t    strobe;
  logic          padSync;
  logic [CW-1:0] cnt;

  rstseq_ctrl #(
    .MIN_PHASE (MIN_PHASE),
    .STAB_SHORT(STAB_SHORT),
    .STAB_LONG (STAB_LONG),
    .CW        (CW)
  ) uCtrl (
    .clk        (clk),
    .porN       (porN),
    .padSync    (padSync),
    .lowVolt    (lowVolt),
    .wdogPulse  (wdogPulse),
    .badOpPulse (badOpPulse),
    .clkSrcRes  (clkSrcRes),
    .cnt        (cnt),
    .strobe     (strobe),
    .padDriveLow(padDriveLow),
    .coreRstN   (coreRstN)
  );

  rstseq_datapath #(
    .CW(CW)
  ) uDp (
    .clk       (clk),
    .porN      (porN),
    .padIn     (padIn),
    .lowVolt   (lowVolt),
    .wdogPulse (wdogPulse),
    .badOpPulse(badOpPulse),
    .flagClr   (flagClr),
    .strobe    (strobe),
    .padSync   (padSync),
    .cnt       (cnt),
    .wdogFlag  (wdogFlag),
    .lvdFlag   (lvdFlag)
  );

endmodule

// File: tb/sim_reset_cause_sequencer.sv
`timescale 1ns/1ps
module sim_reset_cause_sequencer;

  localparam int MINP = 6;
  localparam int SSH  = 5;
  localparam int SLG  = 12;
  localparam int HOLD_CYC = 3;

  logic clk = 1'b0;
  logic porN = 1'b0;
  logic extLow = 1'b0;
  logic lowVolt = 1'b0, wdogPulse = 1'b0, badOpPulse = 1'b0;
  logic clkSrcRes = 1'b0, flagClr = 1'b0;
  logic padDriveLow, coreRstN, wdogFlag, lvdFlag;
  logic padIn;

  int nChk = 0;
  int nBad = 0;
  bit done = 0;

  always #2 clk = ~clk;

  assign padIn = !(padDriveLow || extLow);

  reset_cause_sequencer #(
    .MIN_PHASE(MINP), .STAB_SHORT(SSH), .STAB_LONG(SLG)
  ) u0 (
    .clk(clk), .porN(porN), .padIn(padIn), .padDriveLow(padDriveLow),
    .lowVolt(lowVolt), .wdogPulse(wdogPulse), .badOpPulse(badOpPulse),
    .clkSrcRes(clkSrcRes), .flagClr(flagClr), .coreRstN(coreRstN),
    .wdogFlag(wdogFlag), .lvdFlag(lvdFlag)
  );

  task automatic chk(input string tag, input int act, input int exp);
    nChk++;
    if (act != exp) begin
      nBad++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // counts from the current falling edge until coreRstN is high
  task automatic measure(output int padCnt, output int coreCnt);
    padCnt = 0; coreCnt = 0;
    for (int i = 0; i < 5000; i++) begin
      if (coreRstN) break;
      if (padDriveLow) padCnt++;
      coreCnt++;
      @(negedge clk);
    end
  endtask

  task automatic waitRun();
    for (int i = 0; i < 5000; i++) begin
      if (coreRstN) break;
      @(negedge clk);
    end
  endtask

  task automatic strobeWd(input bit useBadOp);
    @(negedge clk);
    if (useBadOp) badOpPulse = 1'b1; else wdogPulse = 1'b1;
    @(negedge clk);
    badOpPulse = 1'b0; wdogPulse = 1'b0;
  endtask

  task automatic clearFlags();
    @(negedge clk); flagClr = 1'b1;
    @(negedge clk); flagClr = 1'b0;
  endtask

  initial begin
    #(4 * 200000);
    if (!done) begin
      nChk++; nBad++;
      $display("FAIL watchdog: actual 0 expected 1 (run finished)");
      $display("%0d/%0d checks passed", nChk - nBad, nChk);
      $finish;
    end
  end

  initial begin
    int p, c, n;
    // R9 power-on state
    repeat (3) @(negedge clk);
    chk("R9 pad driven in por", padDriveLow, 1);
    chk("R9 core held in por", coreRstN, 0);
    chk("R9 flags clear in por", {wdogFlag, lvdFlag}, 0);
    porN = 1'b1;
    waitRun();
    chk("R9 core released after por", coreRstN, 1);
    chk("R9 flags after por", {wdogFlag, lvdFlag}, 0);

    // R1 R2 R4 R5 R6: internal pulse sweep over cause and clock source
    for (int src = 0; src < 2; src++) begin
      for (int sel = 0; sel < 2; sel++) begin
        int stab;
        stab = sel ? SLG : SSH;
        @(negedge clk); clkSrcRes = sel[0];
        repeat (2) @(negedge clk);
        strobeWd(src[0]);
        chk("R1 drive starts next edge", padDriveLow, 1);
        measure(p, c);
        chk("R2 drive length", p, MINP);
        chk("R4 R5 core low length", c, MINP + HOLD_CYC + stab);
        chk("R6 wdog flag set", {wdogFlag, lvdFlag}, 2);
        clearFlags();
        chk("R7 clear", {wdogFlag, lvdFlag}, 0);
      end
    end
    @(negedge clk); clkSrcRes = 1'b0;

    // R3: low-supply hold lengths, short and long
    for (int k = 0; k < 2; k++) begin
      int L;
      L = k ? (MINP + 4) : 2;
      @(negedge clk); lowVolt = 1'b1;
      fork
        begin repeat (L) @(negedge clk); lowVolt = 1'b0; end
        begin @(negedge clk); measure(p, c); end
      join
      chk("R3 lvd drive length", p, (L > MINP) ? L : MINP);
      chk("R3 lvd core low", c, ((L > MINP) ? L : MINP) + HOLD_CYC + SSH);
      chk("R6 lvd flags", {wdogFlag, lvdFlag}, 1);
    end

    // R7: sticky lvd across a watchdog reset, R6 external clears wdog only
    strobeWd(1'b0);
    measure(p, c);
    chk("R7 lvd sticky after wdog", {wdogFlag, lvdFlag}, 3);

    // R1 R4: external hold
    @(negedge clk); extLow = 1'b1;
    @(negedge clk);
    chk("R1 ext not yet after 1 edge", padDriveLow, 0);
    @(negedge clk);
    chk("R1 ext not yet after 2 edges", padDriveLow, 0);
    @(negedge clk);
    chk("R1 ext drive after 3 edges", padDriveLow, 1);
    p = 1;
    repeat (MINP + 10) begin
      @(negedge clk);
      if (padDriveLow) p++;
    end
    chk("R2 ext drive length", p, MINP);
    extLow = 1'b0;
    n = 0;
    for (int i = 0; i < 5000; i++) begin
      @(negedge clk);
      if (coreRstN) break;
      n++;
    end
    chk("R4 release after pad high", n, 2 + SSH);
    chk("R6 R7 ext flags", {wdogFlag, lvdFlag}, 1);

    // R7: set wins over simultaneous clear
    @(negedge clk); flagClr = 1'b1; wdogPulse = 1'b1;
    @(negedge clk); flagClr = 1'b0; wdogPulse = 1'b0;
    chk("R7 set beats clear", {wdogFlag, lvdFlag}, 2);
    waitRun();
    clearFlags();
    chk("R7 clear after run", {wdogFlag, lvdFlag}, 0);

    // R8: restart during stabilisation, long clock
    @(negedge clk); clkSrcRes = 1'b1;
    strobeWd(1'b0);
    for (int i = 0; i < 100; i++) begin
      if (!padDriveLow) break;
      @(negedge clk);
    end
    repeat (4) @(negedge clk);
    chk("R8 still in stabilisation", coreRstN, 0);
    badOpPulse = 1'b1;
    @(negedge clk); badOpPulse = 1'b0;
    measure(p, c);
    chk("R8 restart drive", p, MINP);
    chk("R8 restart core low", c, MINP + HOLD_CYC + SLG);

    done = 1;
    $display("%0d/%0d checks passed", nChk - nBad, nChk);
    $finish;
  end

endmodule